// File: doc/BRIEF.md
# GPIO Port with Peripheral Override

This block is a multi-pin general-purpose I/O port. Software reaches it through a simple register bus. Through the bus it sets the direction of each pin, the value each pin drives, open-drain behaviour and the pad pull resistors. The same bus reads back the synchronized pin levels, and it reports and clears per-pin change events. Every pin also has an attached peripheral. The peripheral can take the pad over, but only when it is enabled and actively driving. An enabled peripheral that is idle leaves the port in charge. This makes loop-through possible: the port's own output feeds the peripheral's input on the same pin.

Each pad input passes through a synchronizer chain. The synchronized level serves three consumers: the port read path, the peripheral input and the change-notification logic. That logic compares the current synchronized level with the level one cycle earlier. A rising or falling edge whose per-pin enable is set latches a sticky flag. Any set flag raises a single port interrupt.

Top module: `gpio_ovr_port`

## Requirements
- R1: Register map, indexed by `reg_addr`: 0 direction (1 = drive), 1 output latch, 2 synchronized pin level (read only), 3 open-drain enable, 4 pull-up enable, 5 pull-down enable, 6 rising-edge enable, 7 falling-edge enable, 8 change flags (write 1 to clear), 9 last sampled level (read only). Addresses 10 to 15 read zero and ignore writes. `reg_rdata` is combinational from `reg_addr`, and a write takes effect at the clock edge where `reg_we` is high.
- R2: While `rst_n` is low, every register and flag is zero: all pads are released, pulls are off and `cn_irq` is low.
- R3: For a pin the peripheral does not own, the direction bit drives `pad_oe` and the latch bit drives `pad_out` (push-pull when open-drain is off).
- R4: A level on `pad_in` appears in register 2 and on `per_in` after two clock edges.
- R5: With open-drain set on a pin, a value of 1 releases the pad (`pad_oe` = 0). A value of 0 drives the pad low (`pad_oe` = 1, `pad_out` = 0). `pad_out` is always 0 on that pin.
- R6: `pad_pu` and `pad_pd` equal the pull-up and pull-down enable registers, bit for bit.
- R7: When `per_en` is 1 and `per_act` is 0, the port's direction and latch control the pin, and `per_in` returns the port-driven pad level.
- R8: When `per_en` and `per_act` are both 1, `pad_oe` follows `per_oe` and the value follows `per_out`, and the latch has no effect. Open-drain still applies, and the pin stays readable in register 2.
- R9: When `per_en` is 0, `per_act`, `per_out` and `per_oe` have no effect on the pad.
- R10: A 0-to-1 change of the synchronized level on a pin whose rising enable is set sets that pin's flag at the next clock edge.
- R11: A 1-to-0 change of the synchronized level on a pin whose falling enable is set sets that pin's flag at the next edge. An edge whose enable is clear sets no flag.
- R12: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A new edge in the same cycle as the clear leaves the flag set.
- R13: `cn_irq` is high exactly when at least one flag is set.
- R14: Register 9 holds the synchronized level from one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | NPINS | Write data |
| reg_rdata | output | NPINS | Read data for `reg_addr` |
| pad_in | input | NPINS | Raw pad levels |
| pad_oe | output | NPINS | Pad output enable |
| pad_out | output | NPINS | Pad output value |
| pad_pu | output | NPINS | Pull-up enable to pad |
| pad_pd | output | NPINS | Pull-down enable to pad |
| per_en | input | NPINS | Peripheral enabled on pin |
| per_act | input | NPINS | Peripheral actively driving pin |
| per_out | input | NPINS | Peripheral output value |
| per_oe | input | NPINS | Peripheral output enable |
| per_in | output | NPINS | Synchronized pin level to peripheral |
| cn_irq | output | 1 | Change-notification interrupt |

## Verification
Four behaviours are checked by the assertions on every cycle. Each synchronizer stage must shift its neighbour's value. The last-level register must trail the synchronized level by one edge. Each detected edge must leave its flag set, and a write-1 clear must drop a flag unless a new edge arrives. The interrupt may rise only after an edge was detected. The bench scenarios show the rest: pad ownership under every combination of peripheral enable and active drive, open-drain on both port and peripheral values, edge enables that suppress events, and the register map read back at every address, including the unmapped ones.

// File: rtl/gpio_ovr_pkg.sv
`timescale 1ns/1ps
package gpio_ovr_pkg;
   localparam int unsigned ADDR_W = 4;

   typedef enum logic [ADDR_W-1:0] {
      RA_DIR  = 4'd0,
      RA_LAT  = 4'd1,
      RA_PIN  = 4'd2,
      RA_ODEN = 4'd3,
      RA_PUEN = 4'd4,
      RA_PDEN = 4'd5,
      RA_RISE = 4'd6,
      RA_FALL = 4'd7,
      RA_FLAG = 4'd8,
      RA_LVL  = 4'd9
   } reg_addr_e;
endpackage

// File: rtl/gpio_ovr_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a bus of independent single-bit inputs.
module gpio_ovr_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_ovr_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("gpio_ovr_sync: W must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      end else begin
         stg[0] <= din;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign dout = stg[STAGES-1];

   for (genvar k = 1; k < STAGES; k++) begin : g_chk
      // R4: every stage carries the previous stage's value one edge later
      a_r4_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> stg[k] == $past(stg[k-1]));
   end
endmodule

// File: rtl/gpio_ovr_pinmux.sv
`timescale 1ns/1ps
// Per-pin ownership resolution between port registers and peripheral.
module gpio_ovr_pinmux #(
   parameter int unsigned W         = 8,
   parameter bit          OD_ENABLE = 1'b1
) (
   input  logic [W-1:0] dir,
   input  logic [W-1:0] lat,
   input  logic [W-1:0] oden,
   input  logic [W-1:0] per_en,
   input  logic [W-1:0] per_act,
   input  logic [W-1:0] per_out,
   input  logic [W-1:0] per_oe,
   output logic [W-1:0] pad_oe,
   output logic [W-1:0] pad_out
);
   logic [W-1:0] owned;
   logic [W-1:0] src_oe;
   logic [W-1:0] src_val;
   logic [W-1:0] od_eff;

   // a peripheral owns a pin only while enabled and actively driving
   assign owned = per_en & per_act;

   for (genvar i = 0; i < W; i++) begin : g_pin
      assign src_oe[i]  = owned[i] ? per_oe[i]  : dir[i];
      assign src_val[i] = owned[i] ? per_out[i] : lat[i];
   end

   if (OD_ENABLE) begin : g_od
      assign od_eff = oden;
   end else begin : g_no_od
      assign od_eff = '0;
   end

   // open-drain: a 1 releases the pad, a 0 pulls it low
   assign pad_oe  = src_oe & ~(od_eff & src_val);
   assign pad_out = src_val & ~od_eff;
endmodule

// File: rtl/gpio_ovr_cn.sv
`timescale 1ns/1ps
// Per-pin edge detection with sticky write-1-to-clear flags.
module gpio_ovr_cn #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin,
   input  logic [W-1:0] rise_en,
   input  logic [W-1:0] fall_en,
   input  logic [W-1:0] clr,
   output logic [W-1:0] flag,
   output logic [W-1:0] lvl,
   output logic         irq
);
   logic [W-1:0] lvl_q;
   logic [W-1:0] flag_q;
   logic [W-1:0] set_v;

   assign set_v = (pin & ~lvl_q & rise_en) | (~pin & lvl_q & fall_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= '0;
         flag_q <= '0;
      end else begin
         lvl_q  <= pin;
         flag_q <= (flag_q & ~clr) | set_v;
      end
   end

   assign flag = flag_q;
   assign lvl  = lvl_q;
   assign irq  = |flag_q;

   // R14: level status trails the synchronized level by one edge
   a_r14_lvl_trails: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> lvl == $past(pin));

   // R10 R11: a detected edge leaves its flag set
   a_r10_r11_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (set_v != '0) |=> ((flag & $past(set_v)) == $past(set_v)));

   // R12: write-1 clear without a coincident edge empties the flag
   a_r12_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr & ~set_v) != '0) |=> ((flag & $past(clr & ~set_v)) == '0));

   // R13: interrupt can only rise after an edge was detected
   a_r13_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(set_v != '0));
endmodule

// File: rtl/gpio_ovr_port.sv
`timescale 1ns/1ps
// GPIO port with register bus, peripheral override and change notification.
module gpio_ovr_port
   import gpio_ovr_pkg::*;
#(
   parameter int unsigned NPINS       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          OD_ENABLE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [NPINS-1:0]  reg_wdata,
   output logic [NPINS-1:0]  reg_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_oe,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_pu,
   output logic [NPINS-1:0]  pad_pd,
   input  logic [NPINS-1:0]  per_en,
   input  logic [NPINS-1:0]  per_act,
   input  logic [NPINS-1:0]  per_out,
   input  logic [NPINS-1:0]  per_oe,
   output logic [NPINS-1:0]  per_in,
   output logic              cn_irq
);
   if (NPINS < 1 || NPINS > 64) begin : g_bad_npins
      $error("gpio_ovr_port: NPINS must be in 1..64");
   end

   logic [NPINS-1:0] r_dir, r_lat, r_oden, r_pu, r_pd, r_rise, r_fall;
   logic [NPINS-1:0] pin_sync, cn_flag, cn_lvl, flag_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_dir  <= '0;
         r_lat  <= '0;
         r_oden <= '0;
         r_pu   <= '0;
         r_pd   <= '0;
         r_rise <= '0;
         r_fall <= '0;
      end else if (reg_we) begin
         case (reg_addr)
            RA_DIR:  r_dir  <= reg_wdata;
            RA_LAT:  r_lat  <= reg_wdata;
            RA_ODEN: r_oden <= reg_wdata;
            RA_PUEN: r_pu   <= reg_wdata;
            RA_PDEN: r_pd   <= reg_wdata;
            RA_RISE: r_rise <= reg_wdata;
            RA_FALL: r_fall <= reg_wdata;
            default: ;
         endcase
      end
   end

   assign flag_clr = (reg_we && reg_addr == RA_FLAG) ? reg_wdata : '0;

   always_comb begin
      case (reg_addr)
         RA_DIR:  reg_rdata = r_dir;
         RA_LAT:  reg_rdata = r_lat;
         RA_PIN:  reg_rdata = pin_sync;
         RA_ODEN: reg_rdata = r_oden;
         RA_PUEN: reg_rdata = r_pu;
         RA_PDEN: reg_rdata = r_pd;
         RA_RISE: reg_rdata = r_rise;
         RA_FALL: reg_rdata = r_fall;
         RA_FLAG: reg_rdata = cn_flag;
         RA_LVL:  reg_rdata = cn_lvl;
         default: reg_rdata = '0;
      endcase
   end

   gpio_ovr_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pad_in),
      .dout  (pin_sync)
   );

   gpio_ovr_pinmux #(.W(NPINS), .OD_ENABLE(OD_ENABLE)) u_mux (
      .dir     (r_dir),
      .lat     (r_lat),
      .oden    (r_oden),
      .per_en  (per_en),
      .per_act (per_act),
      .per_out (per_out),
      .per_oe  (per_oe),
      .pad_oe  (pad_oe),
      .pad_out (pad_out)
   );

   gpio_ovr_cn #(.W(NPINS)) u_cn (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (pin_sync),
      .rise_en (r_rise),
      .fall_en (r_fall),
      .clr     (flag_clr),
      .flag    (cn_flag),
      .lvl     (cn_lvl),
      .irq     (cn_irq)
   );

   assign pad_pu = r_pu;
   assign pad_pd = r_pd;
   assign per_in = pin_sync;
endmodule

// File: tb/gpio_ovr_port_test.sv
`timescale 1ns/1ps
module gpio_ovr_port_test;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_we = 1'b0;
   logic [3:0]   reg_addr = '0;
   logic [N-1:0] reg_wdata = '0;
   logic [N-1:0] reg_rdata;
   logic [N-1:0] pad_in = '0;
   logic [N-1:0] pad_oe, pad_out, pad_pu, pad_pd, per_in;
   logic [N-1:0] per_en = '0, per_act = '0, per_out = '0, per_oe = '0;
   logic         cn_irq;

   always #2 clk = ~clk;

   gpio_ovr_port #(.NPINS(N)) uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd),
      .per_en(per_en), .per_act(per_act), .per_out(per_out), .per_oe(per_oe),
      .per_in(per_in), .cn_irq(cn_irq)
   );

   int    errors = 0;
   int    checks = 0;
   bit    done = 0;
   string cur_req = "R2";

   // behavioural reference state
   bit [N-1:0] m_dir, m_lat, m_od, m_pu, m_pd, m_rise, m_fall, m_flag, m_lvl;
   bit [N-1:0] m_hist[$];   // sampled pad history, newest first

   function automatic bit [N-1:0] m_pin();
      return (m_hist.size() >= 2) ? m_hist[1] : '0;
   endfunction

   task automatic m_reset();
      m_dir = 0; m_lat = 0; m_od = 0; m_pu = 0; m_pd = 0;
      m_rise = 0; m_fall = 0; m_flag = 0; m_lvl = 0;
      m_hist.delete();
      m_hist.push_front('0);
      m_hist.push_front('0);
   endtask

   task automatic m_edge();
      bit [N-1:0] cur, rs, fl, clr;
      if (!rst_n) begin m_reset(); return; end
      cur = m_pin();
      rs  = cur & ~m_lvl & m_rise;
      fl  = ~cur & m_lvl & m_fall;
      clr = (reg_we && reg_addr == 4'd8) ? reg_wdata : '0;
      m_flag = (m_flag & ~clr) | rs | fl;
      m_lvl  = cur;
      m_hist.push_front(pad_in);
      while (m_hist.size() > 2) void'(m_hist.pop_back());
      if (reg_we) begin
         case (reg_addr)
            4'd0: m_dir  = reg_wdata;
            4'd1: m_lat  = reg_wdata;
            4'd3: m_od   = reg_wdata;
            4'd4: m_pu   = reg_wdata;
            4'd5: m_pd   = reg_wdata;
            4'd6: m_rise = reg_wdata;
            4'd7: m_fall = reg_wdata;
            default: ;
         endcase
      end
   endtask

   task automatic chk(string what, logic [N-1:0] act, logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s act=%h exp=%h t=%0t", cur_req, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      bit [N-1:0] e_oe, e_out, e_rd;
      for (int i = 0; i < N; i++) begin
         bit own, den, val;
         own = per_en[i] && per_act[i];
         den = own ? per_oe[i] : m_dir[i];
         val = own ? per_out[i] : m_lat[i];
         if (m_od[i]) begin e_oe[i] = den && !val; e_out[i] = 1'b0; end
         else         begin e_oe[i] = den;         e_out[i] = val;  end
      end
      case (reg_addr)
         4'd0: e_rd = m_dir;   4'd1: e_rd = m_lat;  4'd2: e_rd = m_pin();
         4'd3: e_rd = m_od;    4'd4: e_rd = m_pu;   4'd5: e_rd = m_pd;
         4'd6: e_rd = m_rise;  4'd7: e_rd = m_fall; 4'd8: e_rd = m_flag;
         4'd9: e_rd = m_lvl;   default: e_rd = '0;
      endcase
      chk("pad_oe", pad_oe, e_oe);
      chk("pad_out", pad_out, e_out);
      chk("pad_pu", pad_pu, m_pu);
      chk("pad_pd", pad_pd, m_pd);
      chk("per_in", per_in, m_pin());
      chk("reg_rdata", reg_rdata, e_rd);
      chk("cn_irq", {{(N-1){1'b0}}, cn_irq}, {{(N-1){1'b0}}, (m_flag != 0)});
   endtask

   task automatic tick();
      @(posedge clk);
      m_edge();
      #1;
      compare();
   endtask

   task automatic wr(int a, bit [N-1:0] d);
      reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic rd(int a);
      reg_addr = 4'(a);
      tick();
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL %s watchdog expired", cur_req);
         summary();
         $finish;
      end
   end

   initial begin
      m_reset();
      // R2: reset state
      cur_req = "R2";
      pad_in = 8'hFF;
      repeat (3) tick();
      for (int a = 0; a < 16; a++) rd(a);
      rst_n = 1'b1;
      pad_in = '0;
      repeat (3) tick();

      // R1: register map write/read-back at every address
      cur_req = "R1";
      for (int a = 0; a < 16; a++) wr(a, 8'(8'h11 * (a + 1)));
      for (int a = 0; a < 16; a++) rd(a);
      for (int a = 0; a < 8; a++) wr(a, '0);
      wr(8, 8'hFF);

      // R3: push-pull drive from direction and latch
      cur_req = "R3";
      wr(0, 8'hFF); wr(1, 8'hA5); rd(1);
      wr(0, 8'h0F); wr(1, 8'h3C); tick();

      // R5: open-drain on port values
      cur_req = "R5";
      wr(0, 8'hFF); wr(3, 8'h0F); wr(1, 8'h55); tick(); wr(1, 8'hAA); tick();

      // R6: pull pass-through
      cur_req = "R6";
      wr(4, 8'h3C); wr(5, 8'hC3); wr(4, 8'h81); rd(4);

      // R4: synchronized read path and peripheral input
      cur_req = "R4";
      reg_addr = 4'd2;
      foreach (pad_in[i]) begin pad_in = 8'(1 << i); tick(); end
      pad_in = 8'h96; repeat (3) tick();
      pad_in = 8'h00; repeat (3) tick();

      // R7: enabled but idle peripheral leaves the port in charge
      cur_req = "R7";
      wr(3, 8'h00);
      per_en = 8'hFF; per_act = 8'h00; per_out = 8'h0F; per_oe = 8'hF0;
      wr(1, 8'hC6); pad_in = 8'hC6; repeat (3) tick();

      // R8: active peripheral overrides latch, pin still readable
      cur_req = "R8";
      per_act = 8'hF0; tick();
      wr(1, 8'h00); tick(); wr(1, 8'hFF); tick();
      wr(3, 8'hFF); per_out = 8'h5A; per_oe = 8'hFF; tick();
      reg_addr = 4'd2; pad_in = 8'h3A; repeat (3) tick();
      wr(3, 8'h00);

      // R9: active without enable has no effect
      cur_req = "R9";
      per_en = 8'h00; per_act = 8'hFF; per_out = 8'hFF; per_oe = 8'h00;
      wr(0, 8'hF0); wr(1, 8'h33); tick();
      per_out = 8'h00; per_oe = 8'hFF; tick();

      // R10: rising-edge flags
      cur_req = "R10";
      wr(8, 8'hFF);
      pad_in = 8'h00; repeat (3) tick();
      wr(6, 8'h55); reg_addr = 4'd8;
      pad_in = 8'hFF; repeat (5) tick();

      // R13: interrupt follows the set flags
      cur_req = "R13";
      wr(8, 8'h05); rd(8); wr(8, 8'h50); rd(8);

      // R11: falling-edge flags, disabled edges ignored
      cur_req = "R11";
      wr(6, 8'h00); wr(7, 8'hAA); reg_addr = 4'd8;
      pad_in = 8'h00; repeat (5) tick();
      pad_in = 8'hFF; repeat (5) tick();

      // R12: write-1 clear, write 0 keeps, coincident edge wins
      cur_req = "R12";
      wr(8, 8'h00); rd(8); wr(8, 8'h0A); rd(8);
      wr(6, 8'hFF); wr(7, 8'hFF);
      pad_in = 8'h00; tick(); tick();
      wr(8, 8'hFF); rd(8);

      // R14: last-level register during toggling
      cur_req = "R14";
      reg_addr = 4'd9;
      for (int k = 0; k < 12; k++) begin pad_in = 8'(k * 37); tick(); end

      // mixed random traffic over all features
      cur_req = "R3";
      for (int k = 0; k < 600; k++) begin
         pad_in  = 8'($urandom);
         per_en  = 8'($urandom);
         per_act = 8'($urandom);
         per_out = 8'($urandom);
         per_oe  = 8'($urandom);
         reg_we  = ($urandom % 3) == 0;
         reg_addr = 4'($urandom % 12);
         reg_wdata = 8'($urandom);
         cur_req = (k % 2) ? "R8" : "R12";
         tick();
      end
      reg_we = 1'b0;

      done = 1;
      summary();
      $finish;
   end
endmodule